// File: doc/BRIEF.md
# Multi-Page-Size Associative Translation Lookup

This block holds a set of address-translation entries and resolves a 64-bit virtual address against all of them at once. Each entry pairs a virtual page tag and a 13-bit context with a physical page number and a flag set: valid, a two-bit page-size code, global, privileged, writable, side-effect, no-fault-only, plus a used flag kept by the block itself. Software-side logic loads entries through a write port by index; choosing a victim and walking page tables happen elsewhere.

A lookup names the virtual address, whether it is a store, whether it comes from user mode, and which context to compare against (primary, secondary, or the nucleus context of zero). One clock later the block answers with exactly one of: translated hit, miss, privilege fault or write-protection fault, together with a 41-bit physical address. Faults load a fault status register, a fault address register and a tag-access register; misses load only the tag-access register. When translation is switched off, the virtual address passes straight through, cut to 41 bits.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0, `fsr_valid`, `fsr_ovf`, `fsr_priv`, `fsr_write` are 0, `used_flags` is all zero, and every entry is invalid, so any enabled lookup misses.
- R2: An enabled lookup hits an entry that is valid, that is global or whose context equals the selected context, and whose virtual page equals the request address with the low address bits ignored according to the size code (0: bits 12..0, 8 KB; 1: bits 15..0, 64 KB; 2: bits 18..0, 512 KB; 3: bits 21..0, 4 MB). The hit entry's side-effect and no-fault-only flags appear on `rsp_side` and `rsp_nfo`.
- R3: `req_mode` selects the compare context: 0 uses `pri_ctx`, 1 uses `sec_ctx`, 2 and 3 use context zero.
- R4: On an enabled hit, `rsp_pa` is ((entry PA & M) | (VA & ~M)) & 0x1FFFFFFE000, with M clearing the bits the size code ignores; bits 12..0 of `rsp_pa` are zero and entry PA bits under the size mask are discarded.
- R5: With `mmu_en` low, every lookup returns a hit with `rsp_pa` equal to bits 40..0 of the request address, raises no fault and leaves the fault registers unchanged.
- R6: When several valid entries match, the lowest-indexed one supplies the result.
- R7: A user-mode access to a privileged entry gives `rsp_priv_fault`, sets `fsr_valid` and `fsr_priv`, sets `fsr_write` to the store bit, latches the VA into `far`, and loads `tag_access` with (VA & ~0x1FFF) | context; this fault takes precedence over write protection.
- R8: A store to a non-writable entry without a privilege fault gives `rsp_prot_fault` and the same register updates as R7 except `fsr_priv` is 0.
- R9: A miss gives `rsp_miss` and loads `tag_access` with (VA & ~0x1FFF) | context, leaving `far` and the fault status bits unchanged.
- R10: A fault arriving while `fsr_valid` is already 1 sets `fsr_ovf`; `fsr_clr` zeroes the status bits; a clear and a fault in the same cycle leave the new fault recorded with `fsr_ovf` 0.
- R11: A translated hit sets the entry's bit in `used_flags`; faults and misses do not; writing an entry clears its used bit, and a write wins over a same-cycle hit to that index; a lookup in the cycle of a write to the matching entry sees the old contents.
- R12: Each response appears exactly one cycle after `req_valid`; `rsp_valid` is 0 in cycles with no request one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_en | input | 1 | Translation enable; low means pass-through |
| pri_ctx | input | 13 | Primary context value |
| sec_ctx | input | 13 | Secondary context value |
| wr_en | input | 1 | Load the entry at `wr_idx` |
| wr_idx | input | 6 | Entry index to load |
| wr_vpn | input | 51 | Virtual page tag, VA bits 63..13 |
| wr_ctx | input | 13 | Entry context |
| wr_ppn | input | 28 | Physical page, PA bits 40..13 |
| wr_valid | input | 1 | Entry valid flag |
| wr_size | input | 2 | Page-size code |
| wr_global | input | 1 | Match any context |
| wr_priv | input | 1 | Privileged-only entry |
| wr_writable | input | 1 | Stores allowed |
| wr_side | input | 1 | Side-effect flag |
| wr_nfo | input | 1 | No-fault-only flag |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_store | input | 1 | Request is a store |
| req_user | input | 1 | Request from user mode |
| req_mode | input | 2 | Context select |
| fsr_clr | input | 1 | Clear fault status bits |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translated or pass-through hit |
| rsp_miss | output | 1 | No entry matched |
| rsp_priv_fault | output | 1 | Privilege fault |
| rsp_prot_fault | output | 1 | Write-protection fault |
| rsp_pa | output | 41 | Physical address |
| rsp_side | output | 1 | Side-effect flag of hit entry |
| rsp_nfo | output | 1 | No-fault-only flag of hit entry |
| fsr_valid | output | 1 | Fault status valid |
| fsr_ovf | output | 1 | Fault overwritten before clear |
| fsr_priv | output | 1 | Last fault was privilege |
| fsr_write | output | 1 | Last fault was a store |
| far | output | 64 | Fault address |
| tag_access | output | 64 | Page address plus context of last fault or miss |
| used_flags | output | 64 | Per-entry used bits |

## Verification
Two pairs of functions can land on one clock edge: fault capture with a status clear, and an entry write with a lookup that hits the same entry. The bench provokes the first by raising `fsr_clr` in the very cycle of a faulting request while the status is already valid, and judges it by `fsr_valid` 1 with `fsr_ovf` 0. It provokes the second by writing new physical bits into an entry while requesting its address, and expects the old physical address in the response, a cleared used bit afterwards, and the new address on the following lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Each size code step widens the ignored page field by this many bits.
  localparam int SIZE_STEP = 3;

  typedef enum logic [1:0] {
    SEL_PRIMARY     = 2'd0,
    SEL_SECONDARY   = 2'd1,
    SEL_NUCLEUS     = 2'd2,
    SEL_NUCLEUS_ALT = 2'd3
  } ctx_sel_e;

  typedef enum logic [1:0] {
    KIND_HIT  = 2'd0,
    KIND_MISS = 2'd1,
    KIND_PRIV = 2'd2,
    KIND_PROT = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic       valid;
    logic [1:0] size;
    logic       glob;
    logic       priv;
    logic       wr_ok;
    logic       side;
    logic       nfo;
  } tte_flags_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int VPN_W = 51,
  parameter int PPN_W = 28,
  parameter int CTX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  tte_flags_t       wr_flags,
  input  logic             set_used,
  input  logic [IDX_W-1:0] set_idx,
  output logic [VPN_W-1:0] vpn_q   [N],
  output logic [CTX_W-1:0] ctx_q   [N],
  output logic [PPN_W-1:0] ppn_q   [N],
  output tte_flags_t       flags_q [N],
  output logic [N-1:0]     used_q
);

  logic [N-1:0] wr_sel;
  logic [N-1:0] used_d;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign wr_sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  // Used bits: a hit sets, a write clears and wins on the same index.
  always_comb begin
    used_d = used_q;
    if (set_used) used_d[set_idx] = 1'b1;
    if (wr_en)    used_d[wr_idx]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      used_q <= used_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) flags_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_sel[i]) flags_q[i] <= wr_flags;
      end
    end
  end

  // Tag and page fields carry no reset; the valid flag guards them.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_sel[i]) begin
        vpn_q[i] <= wr_vpn;
        ctx_q[i] <= wr_ctx;
        ppn_q[i] <= wr_ppn;
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int VPN_W = 51,
  parameter int PPN_W = 28,
  parameter int CTX_W = 13
) (
  input  logic [VPN_W-1:0] vpn_q   [N],
  input  logic [CTX_W-1:0] ctx_q   [N],
  input  logic [PPN_W-1:0] ppn_q   [N],
  input  tte_flags_t       flags_q [N],
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [CTX_W-1:0] look_ctx,
  output logic             any_hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output tte_flags_t       hit_flags
);

  logic [N-1:0]     hit_vec;
  logic [PPN_W-1:0] sel_ign;

  // One comparator per entry, each with its own size-dependent mask.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [VPN_W-1:0] ign;
    logic             ctx_ok;
    logic             page_ok;
    assign ign     = ~({VPN_W{1'b1}} << (SIZE_STEP * int'(flags_q[g].size)));
    assign ctx_ok  = flags_q[g].glob || (ctx_q[g] == look_ctx);
    assign page_ok = (((vpn_q[g] ^ look_vpn) & ~ign) == '0);
    assign hit_vec[g] = flags_q[g].valid && ctx_ok && page_ok;
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hit_flags = flags_q[hit_idx];
    sel_ign   = ~({PPN_W{1'b1}} << (SIZE_STEP * int'(hit_flags.size)));
    hit_ppn   = (ppn_q[hit_idx] & ~sel_ign) | (look_vpn[PPN_W-1:0] & sel_ign);
  end

endmodule

// File: rtl/tlb_fault_status.sv
module tlb_fault_status #(
  parameter int VA_W       = 64,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_fault,
  input  logic             upd_miss,
  input  logic             flt_priv,
  input  logic             flt_store,
  input  logic             clr,
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic             fsr_valid,
  output logic             fsr_ovf,
  output logic             fsr_priv,
  output logic             fsr_write,
  output logic [VA_W-1:0]  far,
  output logic [VA_W-1:0]  tag_access
);

  logic            valid_d, ovf_d, priv_d, write_d;
  logic [VA_W-1:0] far_d, tag_d;
  logic            far_en, tag_en;

  always_comb begin
    valid_d = fsr_valid;
    ovf_d   = fsr_ovf;
    priv_d  = fsr_priv;
    write_d = fsr_write;
    if (clr) begin
      valid_d = 1'b0;
      ovf_d   = 1'b0;
      priv_d  = 1'b0;
      write_d = 1'b0;
    end
    if (upd_fault) begin
      ovf_d   = fsr_valid && !clr;
      valid_d = 1'b1;
      priv_d  = flt_priv;
      write_d = flt_store;
    end
    far_en = upd_fault;
    far_d  = va;
    tag_en = upd_fault || upd_miss;
    tag_d  = {va[VA_W-1:PAGE_SHIFT], PAGE_SHIFT'(ctx)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_valid <= 1'b0;
      fsr_ovf   <= 1'b0;
      fsr_priv  <= 1'b0;
      fsr_write <= 1'b0;
    end else begin
      fsr_valid <= valid_d;
      fsr_ovf   <= ovf_d;
      fsr_priv  <= priv_d;
      fsr_write <= write_d;
    end
  end

  always_ff @(posedge clk) begin
    if (far_en) far <= far_d;
    if (tag_en) tag_access <= tag_d;
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int VA_W        = 64,
  parameter int PA_W        = 41,
  parameter int CTX_W       = 13,
  parameter int PAGE_SHIFT  = 13,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int VPN_W      = VA_W - PAGE_SHIFT,
  localparam int PPN_W      = PA_W - PAGE_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mmu_en,
  input  logic [CTX_W-1:0]       pri_ctx,
  input  logic [CTX_W-1:0]       sec_ctx,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic [CTX_W-1:0]       wr_ctx,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic                   wr_valid,
  input  logic [1:0]             wr_size,
  input  logic                   wr_global,
  input  logic                   wr_priv,
  input  logic                   wr_writable,
  input  logic                   wr_side,
  input  logic                   wr_nfo,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic                   req_store,
  input  logic                   req_user,
  input  logic [1:0]             req_mode,
  input  logic                   fsr_clr,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_priv_fault,
  output logic                   rsp_prot_fault,
  output logic [PA_W-1:0]        rsp_pa,
  output logic                   rsp_side,
  output logic                   rsp_nfo,
  output logic                   fsr_valid,
  output logic                   fsr_ovf,
  output logic                   fsr_priv,
  output logic                   fsr_write,
  output logic [VA_W-1:0]        far,
  output logic [VA_W-1:0]        tag_access,
  output logic [NUM_ENTRIES-1:0] used_flags
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [VPN_W-1:0] vpn_q   [NUM_ENTRIES];
  logic [CTX_W-1:0] ctx_q   [NUM_ENTRIES];
  logic [PPN_W-1:0] ppn_q   [NUM_ENTRIES];
  tte_flags_t       flags_q [NUM_ENTRIES];
  tte_flags_t       wr_flags;
  tte_flags_t       hit_flags;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic [CTX_W-1:0] look_ctx;
  rsp_kind_e        kind_d, kind_q;
  logic [PA_W-1:0]  pa_d, pa_q;
  logic             side_d, side_q, nfo_d, nfo_q;
  logic             rsp_valid_q;
  logic             set_used;

  assign wr_flags = '{valid: wr_valid, size: wr_size, glob: wr_global,
                      priv: wr_priv, wr_ok: wr_writable, side: wr_side,
                      nfo: wr_nfo};

  tlb_entry_store #(
    .N(NUM_ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ctx(wr_ctx), .wr_ppn(wr_ppn), .wr_flags(wr_flags),
    .set_used(set_used), .set_idx(hit_idx),
    .vpn_q(vpn_q), .ctx_q(ctx_q), .ppn_q(ppn_q), .flags_q(flags_q),
    .used_q(used_flags)
  );

  always_comb begin
    case (ctx_sel_e'(req_mode))
      SEL_PRIMARY:   look_ctx = pri_ctx;
      SEL_SECONDARY: look_ctx = sec_ctx;
      default:       look_ctx = '0;
    endcase
  end

  tlb_match #(
    .N(NUM_ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W)
  ) u_match (
    .vpn_q(vpn_q), .ctx_q(ctx_q), .ppn_q(ppn_q), .flags_q(flags_q),
    .look_vpn(req_va[VA_W-1:PAGE_SHIFT]), .look_ctx(look_ctx),
    .any_hit(any_hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
    .hit_flags(hit_flags)
  );

  // Outcome decision: privilege is checked before write protection.
  always_comb begin
    pa_d   = {hit_ppn, PAGE_SHIFT'(0)};
    side_d = hit_flags.side;
    nfo_d  = hit_flags.nfo;
    if (!mmu_en) begin
      kind_d = KIND_HIT;
      pa_d   = req_va[PA_W-1:0];
      side_d = 1'b0;
      nfo_d  = 1'b0;
    end else if (!any_hit) begin
      kind_d = KIND_MISS;
      pa_d   = '0;
      side_d = 1'b0;
      nfo_d  = 1'b0;
    end else if (hit_flags.priv && req_user) begin
      kind_d = KIND_PRIV;
    end else if (req_store && !hit_flags.wr_ok) begin
      kind_d = KIND_PROT;
    end else begin
      kind_d = KIND_HIT;
    end
  end

  assign set_used = req_valid && mmu_en && (kind_d == KIND_HIT);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      kind_q <= kind_d;
      pa_q   <= pa_d;
      side_q <= side_d;
      nfo_q  <= nfo_d;
    end
  end

  tlb_fault_status #(
    .VA_W(VA_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_status (
    .clk(clk), .rst_n(rst_q),
    .upd_fault(req_valid && (kind_d == KIND_PRIV || kind_d == KIND_PROT)),
    .upd_miss(req_valid && (kind_d == KIND_MISS)),
    .flt_priv(kind_d == KIND_PRIV), .flt_store(req_store), .clr(fsr_clr),
    .va(req_va), .ctx(look_ctx),
    .fsr_valid(fsr_valid), .fsr_ovf(fsr_ovf), .fsr_priv(fsr_priv),
    .fsr_write(fsr_write), .far(far), .tag_access(tag_access)
  );

  assign rsp_valid      = rsp_valid_q;
  assign rsp_hit        = rsp_valid_q && (kind_q == KIND_HIT);
  assign rsp_miss       = rsp_valid_q && (kind_q == KIND_MISS);
  assign rsp_priv_fault = rsp_valid_q && (kind_q == KIND_PRIV);
  assign rsp_prot_fault = rsp_valid_q && (kind_q == KIND_PROT);
  assign rsp_pa         = pa_q;
  assign rsp_side       = rsp_valid_q && side_q;
  assign rsp_nfo        = rsp_valid_q && nfo_q;

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int VA_W = 64,
  parameter int PA_W = 41
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mmu_en,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic            fsr_clr,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_priv_fault,
  input logic            rsp_prot_fault,
  input logic [PA_W-1:0] rsp_pa,
  input logic            fsr_valid,
  input logic            fsr_ovf,
  input logic            fsr_priv,
  input logic [VA_W-1:0] far
);

  // R12
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R12
  no_idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_priv_fault, rsp_prot_fault}) == 1);

  // R5
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(mmu_en)) |->
      (rsp_hit && rsp_pa == $past(req_va[PA_W-1:0]) && $stable(fsr_valid)));

  // R4
  page_aligned_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && $past(mmu_en)) |-> (rsp_pa[12:0] == 13'd0));

  // R7
  priv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_priv_fault |-> (fsr_valid && fsr_priv && far == $past(req_va)));

  // R8
  prot_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_fault |-> (fsr_valid && !fsr_priv && far == $past(req_va)));

  // R9
  miss_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss && !$past(fsr_clr)) |-> ($stable(far) && $stable(fsr_valid)));

  // R10
  overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_priv_fault || rsp_prot_fault) && $past(fsr_valid) && !$past(fsr_clr))
      |-> fsr_ovf);

endmodule

bind tlb_lookup tlb_lookup_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .mmu_en(mmu_en), .req_valid(req_valid),
  .req_va(req_va), .fsr_clr(fsr_clr), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_priv_fault(rsp_priv_fault),
  .rsp_prot_fault(rsp_prot_fault), .rsp_pa(rsp_pa), .fsr_valid(fsr_valid),
  .fsr_ovf(fsr_ovf), .fsr_priv(fsr_priv), .far(far)
);

// File: tb/tb_tlb_lookup.sv
module tb_tlb_lookup;

  logic        clk;
  logic        rst_n;
  logic        mmu_en;
  logic [12:0] pri_ctx, sec_ctx;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [50:0] wr_vpn;
  logic [12:0] wr_ctx;
  logic [27:0] wr_ppn;
  logic        wr_valid, wr_global, wr_priv, wr_writable, wr_side, wr_nfo;
  logic [1:0]  wr_size;
  logic        req_valid;
  logic [63:0] req_va;
  logic        req_store, req_user;
  logic [1:0]  req_mode;
  logic        fsr_clr;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_priv_fault, rsp_prot_fault;
  logic [40:0] rsp_pa;
  logic        rsp_side, rsp_nfo;
  logic        fsr_valid, fsr_ovf, fsr_priv, fsr_write;
  logic [63:0] far, tag_access;
  logic [63:0] used_flags;

  int total = 0;
  int fails = 0;

  tlb_lookup dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_pa(input logic [63:0] epa, input int sz,
                                         input logic [63:0] va);
    logic [63:0] m;
    m = ~((64'd1 << (13 + 3 * sz)) - 64'd1);
    return ((epa & m) | (va & ~m)) & 64'h0000_01FF_FFFF_E000;
  endfunction

  function automatic logic [63:0] exp_tag(input logic [63:0] va, input logic [12:0] c);
    return (va & ~64'h1FFF) | {51'd0, c};
  endfunction

  task automatic put_wr(input int idx, input logic [63:0] va, input logic [12:0] c,
                        input logic [63:0] pa, input bit v, input int sz,
                        input bit g, input bit p, input bit w, input bit se, input bit nf);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = va[63:13]; wr_ctx = c;
    wr_ppn = pa[40:13]; wr_valid = v; wr_size = 2'(sz); wr_global = g;
    wr_priv = p; wr_writable = w; wr_side = se; wr_nfo = nf;
  endtask

  task automatic write_entry(input int idx, input logic [63:0] va, input logic [12:0] c,
                             input logic [63:0] pa, input bit v, input int sz,
                             input bit g, input bit p, input bit w, input bit se, input bit nf);
    @(negedge clk);
    put_wr(idx, va, c, pa, v, sz, g, p, w, se, nf);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_req(input logic [63:0] va, input bit st, input bit usr,
                         input logic [1:0] mode, input bit clr);
    req_valid = 1'b1; req_va = va; req_store = st; req_user = usr;
    req_mode = mode; fsr_clr = clr;
  endtask

  // Drive at a falling edge; the response is sampled at the next falling edge.
  task automatic lookup(input logic [63:0] va, input bit st, input bit usr,
                        input logic [1:0] mode, input bit clr);
    @(negedge clk);
    put_req(va, st, usr, mode, clr);
    @(negedge clk);
    req_valid = 1'b0;
    fsr_clr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk);
    fsr_clr = 1'b1;
    @(negedge clk);
    fsr_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 fsr bits", {60'd0, fsr_valid, fsr_ovf, fsr_priv, fsr_write}, 64'd0);
    check("R1 used_flags", used_flags, 64'd0);
    lookup(64'h0000_1234_5678_A000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R1 empty lookup misses", {63'd0, rsp_miss}, 64'd1);
  endtask

  task automatic t_disabled();
    logic [63:0] va;
    va = 64'hFFFF_1234_5678_9ABC;
    mmu_en = 1'b0;
    lookup(va, 1'b1, 1'b1, 2'd1, 1'b0);
    check("R5 hit", {63'd0, rsp_hit}, 64'd1);
    check("R5 pa", {23'd0, rsp_pa}, {23'd0, va[40:0]});
    check("R5 no fault capture", {63'd0, fsr_valid}, 64'd0);
    mmu_en = 1'b1;
  endtask

  task automatic t_sizes();
    logic [63:0] va;
    write_entry(0, 64'h0000_1234_5678_A000, 13'd5, 64'h0_0123_4000, 1, 0, 0, 0, 1, 0, 0);
    write_entry(1, 64'h0000_0040_0001_0000, 13'd5, 64'h0_0500_0000, 1, 1, 0, 0, 1, 0, 0);
    write_entry(2, 64'h0000_0080_0008_0000, 13'd5, 64'h1_0000_0000, 1, 2, 0, 0, 1, 0, 0);
    write_entry(3, 64'hFFFF_F000_0040_0000, 13'd5, 64'h150_003F_E000, 1, 3, 0, 0, 1, 0, 0);
    va = 64'h0000_1234_5678_A123;
    lookup(va, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R2 8K hit", {63'd0, rsp_hit}, 64'd1);
    check("R4 8K pa", {23'd0, rsp_pa}, exp_pa(64'h0_0123_4000, 0, va));
    lookup(64'h0000_1234_5678_C000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R2 8K next page misses", {63'd0, rsp_miss}, 64'd1);
    va = 64'h0000_0040_0001_E055;
    lookup(va, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R4 64K pa", {23'd0, rsp_pa}, exp_pa(64'h0_0500_0000, 1, va));
    va = 64'h0000_0080_000F_A000;
    lookup(va, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R4 512K pa", {23'd0, rsp_pa}, exp_pa(64'h1_0000_0000, 2, va));
    lookup(64'h0000_0080_0010_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R2 512K outside misses", {63'd0, rsp_miss}, 64'd1);
    va = 64'hFFFF_F000_006A_B123;
    lookup(va, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R2 4M hit", {63'd0, rsp_hit}, 64'd1);
    check("R4 4M pa drops masked entry bits", {23'd0, rsp_pa},
          exp_pa(64'h150_003F_E000, 3, va));
  endtask

  task automatic t_context();
    write_entry(4, 64'h0000_0000_0100_0000, 13'd9, 64'h0_0C00_0000, 1, 0, 0, 0, 1, 0, 1);
    write_entry(5, 64'h0000_0000_0200_0000, 13'd77, 64'h0_0D00_0000, 1, 0, 1, 0, 1, 1, 0);
    lookup(64'h0000_0000_0100_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R3 primary ctx mismatch", {63'd0, rsp_miss}, 64'd1);
    lookup(64'h0000_0000_0100_0000, 1'b0, 1'b0, 2'd1, 1'b0);
    check("R3 secondary ctx hit", {63'd0, rsp_hit}, 64'd1);
    check("R2 nfo flag", {63'd0, rsp_nfo}, 64'd1);
    lookup(64'h0000_0000_0100_0000, 1'b0, 1'b0, 2'd2, 1'b0);
    check("R3 nucleus ctx mismatch", {63'd0, rsp_miss}, 64'd1);
    lookup(64'h0000_0000_0100_0000, 1'b0, 1'b0, 2'd3, 1'b0);
    check("R3 mode 3 nucleus mismatch", {63'd0, rsp_miss}, 64'd1);
    lookup(64'h0000_0000_0200_0000, 1'b0, 1'b0, 2'd2, 1'b0);
    check("R3 global in nucleus", {63'd0, rsp_hit}, 64'd1);
    check("R2 side flag", {63'd0, rsp_side}, 64'd1);
    lookup(64'h0000_0000_0200_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R3 global in primary", {63'd0, rsp_hit}, 64'd1);
  endtask

  task automatic t_priority();
    write_entry(8, 64'h0000_0000_0300_0000, 13'd0, 64'h0_0000_3000, 0, 0, 1, 0, 1, 0, 0);
    write_entry(20, 64'h0000_0000_0300_0000, 13'd0, 64'h0_2000_0000, 1, 0, 1, 0, 1, 0, 0);
    write_entry(10, 64'h0000_0000_0300_0000, 13'd0, 64'h0_1000_0000, 1, 0, 1, 0, 1, 0, 0);
    lookup(64'h0000_0000_0300_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R6 lowest valid index wins", {23'd0, rsp_pa}, 64'h0_1000_0000);
  endtask

  task automatic t_used();
    check("R11 hit set used", {63'd0, used_flags[0]}, 64'd1);
    write_entry(0, 64'h0000_1234_5678_A000, 13'd5, 64'h0_0123_4000, 1, 0, 0, 0, 1, 0, 0);
    check("R11 write clears used", {63'd0, used_flags[0]}, 64'd0);
    write_entry(30, 64'h0000_0000_0700_0000, 13'd0, 64'h0_7000_0000, 1, 0, 1, 0, 1, 0, 0);
    @(negedge clk);
    put_wr(30, 64'h0000_0000_0700_0000, 13'd0, 64'h0_7100_0000, 1, 0, 1, 0, 1, 0, 0);
    put_req(64'h0000_0000_0700_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b0;
    check("R11 same-cycle lookup sees old pa", {23'd0, rsp_pa}, 64'h0_7000_0000);
    check("R11 write beats used set", {63'd0, used_flags[30]}, 64'd0);
    lookup(64'h0000_0000_0700_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R11 new pa after write", {23'd0, rsp_pa}, 64'h0_7100_0000);
    check("R11 used after hit", {63'd0, used_flags[30]}, 64'd1);
  endtask

  task automatic t_priv();
    logic [63:0] va;
    va = 64'h0000_0000_0400_0ABC;
    write_entry(12, 64'h0000_0000_0400_0000, 13'd0, 64'h0_4000_0000, 1, 0, 1, 1, 0, 0, 0);
    lookup(va, 1'b0, 1'b1, 2'd0, 1'b0);
    check("R7 priv fault", {63'd0, rsp_priv_fault}, 64'd1);
    check("R7 fsr valid/ovf/priv/write", {60'd0, fsr_valid, fsr_ovf, fsr_priv, fsr_write},
          64'b1010);
    check("R7 far", far, va);
    check("R7 tag_access", tag_access, exp_tag(va, 13'd5));
    check("R11 fault leaves used clear", {63'd0, used_flags[12]}, 64'd0);
    lookup(va, 1'b1, 1'b1, 2'd0, 1'b0);
    check("R7 priv beats protection", {63'd0, rsp_priv_fault}, 64'd1);
    check("R7 store bit recorded", {63'd0, fsr_write}, 64'd1);
    check("R10 overflow on second fault", {63'd0, fsr_ovf}, 64'd1);
    lookup(va, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R7 kernel access hits", {63'd0, rsp_hit}, 64'd1);
  endtask

  task automatic t_prot();
    logic [63:0] va;
    va = 64'h0000_0000_0500_0040;
    clear_status();
    check("R10 clear zeroes status", {60'd0, fsr_valid, fsr_ovf, fsr_priv, fsr_write},
          64'd0);
    write_entry(13, 64'h0000_0000_0500_0000, 13'd0, 64'h0_5000_0000, 1, 0, 1, 0, 0, 0, 0);
    lookup(va, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R8 prot fault", {63'd0, rsp_prot_fault}, 64'd1);
    check("R8 fsr valid/ovf/priv/write", {60'd0, fsr_valid, fsr_ovf, fsr_priv, fsr_write},
          64'b1001);
    check("R8 tag_access", tag_access, exp_tag(va, 13'd9));
    lookup(va, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R10 overflow", {63'd0, fsr_ovf}, 64'd1);
    lookup(va, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R10 clear with fault: valid", {63'd0, fsr_valid}, 64'd1);
    check("R10 clear with fault: no overflow", {63'd0, fsr_ovf}, 64'd0);
    lookup(va, 1'b0, 1'b0, 2'd1, 1'b0);
    check("R8 load to read-only hits", {63'd0, rsp_hit}, 64'd1);
  endtask

  task automatic t_miss();
    logic [63:0] far_before;
    logic [63:0] va;
    far_before = far;
    va = 64'h0000_0000_0600_1234;
    lookup(va, 1'b0, 1'b0, 2'd1, 1'b0);
    check("R9 miss", {63'd0, rsp_miss}, 64'd1);
    check("R9 tag_access", tag_access, exp_tag(va, 13'd9));
    check("R9 far unchanged", far, far_before);
    check("R9 status unchanged", {62'd0, fsr_valid, fsr_ovf}, 64'b10);
  endtask

  task automatic t_latency();
    lookup(64'h0000_0000_0200_0000, 1'b0, 1'b0, 2'd0, 1'b0);
    check("R12 response after one cycle", {63'd0, rsp_valid}, 64'd1);
    @(negedge clk);
    check("R12 no response without request", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    #(20 * 100000);
    total++;
    fails++;
    $display("FAIL R12 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mmu_en = 1'b1; pri_ctx = 13'd5; sec_ctx = 13'd9;
    wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_ctx = '0; wr_ppn = '0;
    wr_valid = 1'b0; wr_size = '0; wr_global = 1'b0; wr_priv = 1'b0;
    wr_writable = 1'b0; wr_side = 1'b0; wr_nfo = 1'b0;
    req_valid = 1'b0; req_va = '0; req_store = 1'b0; req_user = 1'b0;
    req_mode = '0; fsr_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_disabled();
    t_sizes();
    t_context();
    t_priority();
    t_used();
    t_priv();
    t_prot();
    t_miss();
    t_latency();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule